// File: doc/BRIEF.md
# Indirect-access vectored interrupt controller

This block collects up to 128 interrupt inputs and raises one request line toward a processor. Software never reaches a source through a per-line bit mask. It first writes a source number into a select register, and then every mode, vector, enable, disable, clear and set access goes to that one source only. Each source has a 3-bit priority and one of four trigger types: low level, high level, falling edge or rising edge.

A read of the vector register hands the processor the vector of the best candidate. The best candidate is the pending, enabled source with the highest priority, and equal priorities go to the lower source number. That read also commits the source as in service: its priority is pushed onto an eight-entry nesting stack and its latched request is consumed. After that, only a source of strictly higher priority raises the request line again. Each end-of-interrupt write pops one stack entry. When there is no candidate, the vector read returns a programmable spurious value and the stack does not change.

The register port is a single-cycle strobe. Writes take effect on the clock edge. Read data is registered and is valid one cycle after the strobe.

Top module: `vic_indirect`

## Requirements
- R1: After reset the request output is low, and the status (0x18), spurious (0x3C) and debug (0x6C) registers read 0. A vector read (0x10) returns 0, which is the reset spurious value.
- R2: The select register (0x00) holds a 7-bit source number and reads back. The mode register (0x04) stores bits [6:5] (trigger) and [2:0] (priority) of the selected source and reads other bits as 0. The vector register (0x08) stores a 32-bit value per source. While the selection is at or above NUM_SRC, writes to 0x04, 0x08 and 0x40-0x4C change nothing and reads of 0x04, 0x08 and 0x30 return 0.
- R3: Any write to 0x40 enables the selected source and any write to 0x44 disables it. Bit 0 of 0x30 reads the selected source's enable. A disabled source never drives the request output.
- R4: Trigger encoding in mode[6:5] is 00 low level, 01 high level, 10 falling edge, 11 rising edge. An edge source latches a request on its active transition only. A level source requests for as long as its input is at the active level.
- R5: Any write to 0x48 drops the selected source's latched request. Any write to 0x4C latches a request for it.
- R6: Among pending, enabled sources, the highest priority wins and ties go to the lowest source number. A read of 0x10 returns the winner's vector.
- R7: A vector read that finds a candidate pushes it in service and clears its latched request. Status (0x18) then reads the in-service source number. The request output stays low unless a strictly higher priority source is pending.
- R8: A strictly higher priority source raises the request while a lower one is in service. Any write to 0x38 pops one nesting level and restores the previous source in status.
- R9: The nesting stack holds 8 levels. With 8 levels in service no request is raised. Eight end-of-interrupt writes fully unwind it. An end-of-interrupt write on an empty stack changes nothing.
- R10: A vector read with no candidate returns the spurious register value and leaves the stack and status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt inputs, synchronous to clk |
| cs_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read strobe |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that the interrupt inputs are already synchronous to the clock. They also assume at most one register access per cycle, so a push and a pop can never coincide. The bench drives every input change just after the falling edge and issues one access at a time. It keeps the selection inside the implemented range whenever a test needs a command to take effect. It drives sources to new levels only between accesses, so an edge never lands in the cycle that commits the same source.

// File: rtl/vic_indirect.sv
module vic_indirect #(
  parameter int NUM_SRC = 48,
  parameter int DEPTH   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               cs_i,
  input  logic               we_i,
  input  logic [7:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               irq_o
);
  localparam int SW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int DW = $clog2(DEPTH + 1);
  localparam int LW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  localparam logic [7:0] A_SEL  = 8'h00;
  localparam logic [7:0] A_MODE = 8'h04;
  localparam logic [7:0] A_VEC  = 8'h08;
  localparam logic [7:0] A_IVR  = 8'h10;
  localparam logic [7:0] A_STAT = 8'h18;
  localparam logic [7:0] A_ENRD = 8'h30;
  localparam logic [7:0] A_EOI  = 8'h38;
  localparam logic [7:0] A_SPU  = 8'h3C;
  localparam logic [7:0] A_EN   = 8'h40;
  localparam logic [7:0] A_DIS  = 8'h44;
  localparam logic [7:0] A_CLR  = 8'h48;
  localparam logic [7:0] A_SET  = 8'h4C;
  localparam logic [7:0] A_DBG  = 8'h6C;

  logic [6:0]         sel;
  logic [1:0]         trig [NUM_SRC];
  logic [2:0]         prio [NUM_SRC];
  logic [31:0]        vec  [NUM_SRC];
  logic [NUM_SRC-1:0] en, lat, prev, act, edg;
  logic [31:0]        spur, dbg;
  logic [6:0]         stk_src [DEPTH];
  logic [2:0]         stk_pri [DEPTH];
  logic [DW-1:0]      depth;

  logic          wr, rd, sel_ok;
  logic [SW-1:0] si;
  logic [LW-1:0] top_i, wi;
  logic [2:0]    top_pri, bpri;
  logic [SW-1:0] best;
  logic          found, take, commit;
  logic          cmd_mode, cmd_vec, cmd_en, cmd_dis, cmd_clr, cmd_set, eoi;
  logic [31:0]   rmux;

  assign wr     = cs_i & we_i;
  assign rd     = cs_i & ~we_i;
  assign sel_ok = (32'(sel) < NUM_SRC);
  assign si     = SW'(sel);

  assign cmd_mode = wr && sel_ok && addr_i == A_MODE;
  assign cmd_vec  = wr && sel_ok && addr_i == A_VEC;
  assign cmd_en   = wr && sel_ok && addr_i == A_EN;
  assign cmd_dis  = wr && sel_ok && addr_i == A_DIS;
  assign cmd_clr  = wr && sel_ok && addr_i == A_CLR;
  assign cmd_set  = wr && sel_ok && addr_i == A_SET;
  assign eoi      = wr && addr_i == A_EOI;

  assign top_i   = LW'(depth - DW'(1));
  assign wi      = LW'(depth);
  assign top_pri = (depth == '0) ? 3'd0 : stk_pri[top_i];

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      edg[i] = trig[i][0] ? (src_i[i] & ~prev[i]) : (~src_i[i] & prev[i]);
      act[i] = trig[i][1] ? lat[i] : (lat[i] | ~(src_i[i] ^ trig[i][0]));
    end
  end

  always_comb begin
    found = 1'b0;
    best  = '0;
    bpri  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (act[i] && en[i] && (depth == '0 || prio[i] > top_pri) &&
          (!found || prio[i] > bpri)) begin
        found = 1'b1;
        best  = SW'(i);
        bpri  = prio[i];
      end
    end
  end

  assign take   = found && (depth < DW'(DEPTH));
  assign irq_o  = take;
  assign commit = rd && addr_i == A_IVR && take;

  always_comb begin
    case (addr_i)
      A_SEL:  rmux = {25'd0, sel};
      A_MODE: rmux = sel_ok ? {25'd0, trig[si], 2'b00, prio[si]} : 32'd0;
      A_VEC:  rmux = sel_ok ? vec[si] : 32'd0;
      A_IVR:  rmux = take ? vec[best] : spur;
      A_STAT: rmux = (depth == '0) ? 32'd0 : {25'd0, stk_src[top_i]};
      A_ENRD: rmux = {31'd0, sel_ok & en[si]};
      A_SPU:  rmux = spur;
      A_DBG:  rmux = dbg;
      default: rmux = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel     <= '0;
      spur    <= '0;
      dbg     <= '0;
      en      <= '0;
      lat     <= '0;
      prev    <= '0;
      depth   <= '0;
      rdata_o <= '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        trig[i] <= '0;
        prio[i] <= '0;
        vec[i]  <= '0;
      end
      for (int d = 0; d < DEPTH; d++) begin
        stk_src[d] <= '0;
        stk_pri[d] <= '0;
      end
    end else begin
      prev <= src_i;
      if (wr && addr_i == A_SEL) sel  <= wdata_i[6:0];
      if (wr && addr_i == A_SPU) spur <= wdata_i;
      if (wr && addr_i == A_DBG) dbg  <= wdata_i;
      if (cmd_mode) begin
        trig[si] <= wdata_i[6:5];
        prio[si] <= wdata_i[2:0];
      end
      if (cmd_vec) vec[si] <= wdata_i;
      if (cmd_en)  en[si]  <= 1'b1;
      if (cmd_dis) en[si]  <= 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
        if ((cmd_clr && si == SW'(i)) || (commit && best == SW'(i)))
          lat[i] <= 1'b0;
        if ((cmd_set && si == SW'(i)) || (trig[i][1] && edg[i]))
          lat[i] <= 1'b1;
      end
      if (commit) begin
        stk_src[wi] <= 7'(best);
        stk_pri[wi] <= bpri;
        depth       <= depth + DW'(1);
      end else if (eoi && depth != '0) begin
        depth <= depth - DW'(1);
      end
      if (rd) rdata_o <= rmux;
    end
  end
endmodule

// File: rtl/vic_indirect_chk.sv
module vic_indirect_chk #(
  parameter int NUM_SRC = 48,
  parameter int DEPTH   = 8,
  parameter int DW      = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cs_i,
  input logic               we_i,
  input logic [7:0]         addr_i,
  input logic               irq_o,
  input logic [DW-1:0]      depth,
  input logic [NUM_SRC-1:0] en
);
  logic ivr_rd, eoi_wr;
  assign ivr_rd = cs_i && !we_i && addr_i == 8'h10;
  assign eoi_wr = cs_i && we_i && addr_i == 8'h38;

  assert_push_on_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ivr_rd && irq_o |=> depth == $past(depth) + DW'(1));

  assert_pop_on_eoi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr && depth != '0 |=> depth == $past(depth) - DW'(1));

  assert_depth_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(DEPTH));

  assert_no_irq_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> depth < DW'(DEPTH));

  assert_spurious_keeps_stack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ivr_rd && !irq_o |=> $stable(depth));

  assert_irq_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> en != '0);
endmodule

bind vic_indirect vic_indirect_chk #(.NUM_SRC(NUM_SRC), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .we_i(we_i), .addr_i(addr_i),
  .irq_o(irq_o), .depth(depth), .en(en)
);

// File: tb/vic_indirect_bench.sv
module vic_indirect_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          cs = 1'b0, we = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;
  int            n_run = 0, n_fail = 0;
  bit            done = 1'b0;

  vic_indirect #(.NUM_SRC(NS), .DEPTH(8)) u_vic_indirect (
    .clk(clk), .rst_n(rst_n), .src_i(src), .cs_i(cs), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    tick();
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic rd_reg(logic [7:0] a, output logic [31:0] d);
    cs = 1'b1; we = 1'b0; addr = a;
    tick();
    d = rdata;
    cs = 1'b0;
  endtask

  task automatic cfg(int s, logic [31:0] mode, logic [31:0] v);
    wr_reg(8'h00, 32'(s));
    wr_reg(8'h04, mode);
    wr_reg(8'h08, v);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd_reg(8'h18, d); check("R1 status", d, 32'd0);
    rd_reg(8'h6C, d); check("R1 debug", d, 32'd0);
    rd_reg(8'h3C, d); check("R1 spurious", d, 32'd0);
    rd_reg(8'h10, d); check("R1 vector", d, 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr_reg(8'h3C, 32'h0000_00FF);
    rd_reg(8'h3C, d); check("R10 spurious rw", d, 32'hFF);
    wr_reg(8'h6C, 32'h3);
    rd_reg(8'h6C, d); check("R2 debug rw", d, 32'h3);
    cfg(5, 32'hFFFF_FFFF, 32'h1234);
    rd_reg(8'h04, d); check("R2 mode fields", d, 32'h67);
    rd_reg(8'h08, d); check("R2 vector rw", d, 32'h1234);
    wr_reg(8'h00, 32'd100);
    rd_reg(8'h00, d); check("R2 select rb", d, 32'd100);
    wr_reg(8'h04, 32'h7);
    wr_reg(8'h40, 32'h0);
    rd_reg(8'h04, d); check("R2 out-of-range mode", d, 32'd0);
    rd_reg(8'h30, d); check("R2 out-of-range enable", d, 32'd0);
    check("R2 no irq from bad select", {31'd0, irq}, 32'd0);
    wr_reg(8'h00, 32'd36);
    rd_reg(8'h04, d); check("R2 alias untouched", d, 32'd0);
    wr_reg(8'h00, 32'd5);
    rd_reg(8'h08, d); check("R2 vector kept", d, 32'h1234);
    wr_reg(8'h04, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    cfg(3, 32'h62, 32'h300);
    rd_reg(8'h30, d); check("R3 enable rb off", d, 32'd0);
    src[3] = 1'b1; tick();
    check("R3 disabled silent", {31'd0, irq}, 32'd0);
    wr_reg(8'h40, 32'h0);
    check("R3 enable raises", {31'd0, irq}, 32'd1);
    rd_reg(8'h30, d); check("R3 enable rb on", d, 32'd1);
    wr_reg(8'h44, 32'h0);
    check("R3 disable drops", {31'd0, irq}, 32'd0);
    wr_reg(8'h48, 32'h0);
    wr_reg(8'h40, 32'h0);
    check("R5 clear", {31'd0, irq}, 32'd0);
    wr_reg(8'h4C, 32'h0);
    check("R5 set", {31'd0, irq}, 32'd1);
    rd_reg(8'h10, d); check("R7 vector", d, 32'h300);
    check("R7 irq after commit", {31'd0, irq}, 32'd0);
    rd_reg(8'h18, d); check("R7 status", d, 32'd3);
    wr_reg(8'h38, 32'h0);
    rd_reg(8'h18, d); check("R8 status after eoi", d, 32'd0);
    src[3] = 1'b0; tick();
    check("R4 rising ignores fall", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_trigger();
    logic [31:0] d;
    cfg(7, 32'h41, 32'h700);
    wr_reg(8'h40, 32'h0);
    src[7] = 1'b1; tick();
    check("R4 falling ignores rise", {31'd0, irq}, 32'd0);
    src[7] = 1'b0; tick();
    check("R4 falling latches", {31'd0, irq}, 32'd1);
    rd_reg(8'h10, d); check("R4 falling vector", d, 32'h700);
    wr_reg(8'h38, 32'h0);
    check("R4 falling consumed", {31'd0, irq}, 32'd0);
    cfg(9, 32'h21, 32'h900);
    wr_reg(8'h40, 32'h0);
    check("R4 high level idle", {31'd0, irq}, 32'd0);
    src[9] = 1'b1; tick();
    check("R4 high level active", {31'd0, irq}, 32'd1);
    rd_reg(8'h10, d); check("R4 high level vector", d, 32'h900);
    check("R7 same prio no preempt", {31'd0, irq}, 32'd0);
    wr_reg(8'h38, 32'h0);
    check("R4 level persists", {31'd0, irq}, 32'd1);
    rd_reg(8'h10, d);
    src[9] = 1'b0; tick();
    wr_reg(8'h38, 32'h0);
    check("R4 high level released", {31'd0, irq}, 32'd0);
    wr_reg(8'h44, 32'h0);
    cfg(10, 32'h01, 32'hA00);
    wr_reg(8'h40, 32'h0);
    check("R4 low level active", {31'd0, irq}, 32'd1);
    src[10] = 1'b1; tick();
    check("R4 low level released", {31'd0, irq}, 32'd0);
    wr_reg(8'h44, 32'h0);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    cfg(12, 32'h64, 32'hC00); wr_reg(8'h40, 32'h0);
    cfg(13, 32'h62, 32'hD00); wr_reg(8'h40, 32'h0);
    cfg(14, 32'h64, 32'hE00); wr_reg(8'h40, 32'h0);
    src[12] = 1'b1; src[13] = 1'b1; src[14] = 1'b1; tick();
    rd_reg(8'h10, d); check("R6 tie lowest index", d, 32'hC00);
    rd_reg(8'h18, d); check("R6 status", d, 32'd12);
    check("R7 lower/equal held off", {31'd0, irq}, 32'd0);
    wr_reg(8'h38, 32'h0);
    rd_reg(8'h10, d); check("R6 next tie", d, 32'hE00);
    wr_reg(8'h38, 32'h0);
    rd_reg(8'h10, d); check("R6 lowest prio last", d, 32'hD00);
    wr_reg(8'h38, 32'h0);
    check("R6 all served", {31'd0, irq}, 32'd0);
    rd_reg(8'h10, d); check("R10 spurious vector", d, 32'hFF);
    rd_reg(8'h18, d); check("R10 status unchanged", d, 32'd0);
    src[12] = 1'b0; src[13] = 1'b0; src[14] = 1'b0; tick();
  endtask

  task automatic t_nest();
    logic [31:0] d;
    for (int k = 0; k < 8; k++) begin
      cfg(20 + k, 32'h60 | 32'(k), 32'h1400 + 32'(k));
      wr_reg(8'h40, 32'h0);
    end
    for (int k = 0; k < 8; k++) begin
      src[20 + k] = 1'b1; tick();
      check("R8 preempt raises", {31'd0, irq}, 32'd1);
      rd_reg(8'h10, d); check("R8 nested vector", d, 32'h1400 + 32'(k));
      rd_reg(8'h18, d); check("R8 nested status", d, 32'(20 + k));
    end
    wr_reg(8'h00, 32'd20);
    wr_reg(8'h4C, 32'h0);
    check("R9 full stack silent", {31'd0, irq}, 32'd0);
    rd_reg(8'h10, d); check("R10 spurious when full", d, 32'hFF);
    rd_reg(8'h18, d); check("R10 full status kept", d, 32'd27);
    for (int k = 7; k > 0; k--) begin
      wr_reg(8'h38, 32'h0);
      rd_reg(8'h18, d); check("R8 unwind status", d, 32'(20 + k - 1));
    end
    wr_reg(8'h38, 32'h0);
    rd_reg(8'h18, d); check("R9 fully unwound", d, 32'd0);
    check("R9 pending after unwind", {31'd0, irq}, 32'd1);
    rd_reg(8'h10, d); check("R9 retriggered vector", d, 32'h1400);
    wr_reg(8'h38, 32'h0);
    wr_reg(8'h38, 32'h0);
    rd_reg(8'h18, d); check("R9 empty eoi harmless", d, 32'd0);
    check("R9 idle", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_regs();
    t_enable();
    t_trigger();
    t_priority();
    t_nest();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule